// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block receives one memory access request at a time: a 32-bit virtual address, a flag saying whether the requester runs in user mode, an 8-bit address space identifier, and three control bits. These bits enable translation, lock the store-queue window against user mode, and open the on-chip RAM window to user mode. The block finds out which region of the address map the address falls in. It then decides whether the current mode may reach that region. Where translation applies, it searches a small fully associative TLB and produces a 29-bit physical address.

Each TLB entry covers a page of 1, 4, 64 or 1024 Kbytes. An entry can be private to one identifier or shared by all of them. Entries are loaded through a write port that takes one entry per cycle. The result of a request appears in registers one cycle after the request strobe. It carries an address-error flag, a miss flag or a multiple-hit flag, and the physical address when the access succeeds.

The address map is split by the top address bits. Addresses below 0x80000000 form the low region that both modes can reach. The range from 0x80000000 to 0x9FFFFFFF is the first direct region and the range from 0xA0000000 to 0xBFFFFFFF is the second. The range from 0xC0000000 to 0xDFFFFFFF is the high mapped region. The range from 0xE0000000 up is the control region.

Top module: `vat_xlate`

## Requirements
- R1: After reset, rsp_valid is 0 and every TLB entry is invalid, so a translated request gets a miss until an entry is written.
- R2: rsp_valid is 1 in exactly the cycle after a cycle with req_valid high, and 0 otherwise; the flags and rsp_pa belong to that request.
- R3: A privileged request (req_user=0) never raises rsp_addr_err, whatever the address.
- R4: A user request to an address from 0x80000000 through 0xFFFFFFFF raises rsp_addr_err unless R5 or R6 opens it; on an address error rsp_pa, rsp_miss and rsp_multi are all 0.
- R5: A user request to 0xE0000000–0xE3FFFFFF is allowed when req_sq_lock is 0 and is an address error when it is 1.
- R6: A user request to 0xE5000000–0xE5FFFFFF is allowed when req_ocram_en is 1 and is an address error when it is 0.
- R7: Addresses from 0x80000000 to 0xBFFFFFFF and from 0xE0000000 up, and every address while req_xlat_en is 0, bypass the TLB: rsp_pa = req_va[28:0] with no miss.
- R8: With req_xlat_en=1, an address below 0x80000000 or from 0xC0000000 to 0xDFFFFFFF is looked up in the TLB. A single matching entry gives rsp_pa = {entry PPN above the page offset, req_va page offset}, where the entry's PPN field holds physical address bits [28:10] and its VPN field holds virtual address bits [31:10].
- R9: Size code 00 selects a 1 KB page, 01 a 4 KB page, 10 a 64 KB page and 11 a 1 MB page. Offset bits of that page are excluded from the VPN compare and taken from req_va.
- R10: An entry matches only when its ASID equals req_asid, unless its shared bit is 1.
- R11: A translated request that matches no valid entry sets rsp_miss with rsp_pa = 0.
- R12: A translated request that matches two or more valid entries sets rsp_multi, with rsp_miss 0 and rsp_pa 0.
- R13: A write with wr_en=1 loads entry wr_idx at the clock edge. A request in the same cycle sees the previous contents, and a request in a later cycle sees the new contents. Writing with wr_valid=0 removes the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_va | input | 32 | Virtual address |
| req_user | input | 1 | 1 = user mode, 0 = privileged |
| req_asid | input | 8 | Address space identifier |
| req_xlat_en | input | 1 | Enables TLB translation |
| req_sq_lock | input | 1 | 1 = store-queue window closed to user mode |
| req_ocram_en | input | 1 | 1 = on-chip RAM window open to user mode |
| wr_en | input | 1 | TLB entry write strobe |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid bit of written entry |
| wr_shared | input | 1 | Shared bit (skip ASID compare) |
| wr_size | input | 2 | Page size code |
| wr_vpn | input | 22 | Virtual page number, VA[31:10] |
| wr_asid | input | 8 | Entry ASID |
| wr_ppn | input | 19 | Physical page number, PA[28:10] |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 29 | Physical address |
| rsp_addr_err | output | 1 | Address error |
| rsp_miss | output | 1 | TLB miss |
| rsp_multi | output | 1 | TLB multiple hit |

## Verification
A TLB write and a lookup can occur in the same cycle. The lookup must use the entries as they stood before that edge. The bench tests this by writing a fresh entry and requesting an address inside its page in the same cycle. It expects a miss for that request, and then a hit with the new physical address for the same request one cycle later. A second overlap is a single request that both fits the user-window rules and lies in a translated region. This case checks that the address error takes precedence and that the miss and multi-hit flags are cleared.

// File: rtl/vat_pkg.sv
package vat_pkg;

   typedef enum logic [2:0] {
      AREA_LOW   = 3'd0,
      AREA_DIR0  = 3'd1,
      AREA_DIR1  = 3'd2,
      AREA_HIGH  = 3'd3,
      AREA_CTRL  = 3'd4
   } area_t;

   localparam int MIN_OFF = 10;

   // extra offset bits beyond the 1 KB minimum, per size code
   function automatic int page_extra(input logic [1:0] sz);
      case (sz)
         2'b00:   return 0;
         2'b01:   return 2;
         2'b10:   return 6;
         default: return 10;
      endcase
   endfunction

endpackage

// File: rtl/vat_area.sv
module vat_area
   import vat_pkg::*;
#(
   parameter int VA_W = 32
) (
   input  logic [VA_W-1:0] va,
   input  logic            user,
   input  logic            sq_lock,
   input  logic            ocram_en,
   input  logic            xlat_en,
   output area_t           area,
   output logic            addr_err,
   output logic            need_xlat
);

   generate
      if (VA_W != 32) begin : g_bad_va
         $error("vat_area: region decode assumes VA_W == 32");
      end
   endgenerate

   logic in_sq, in_oc, user_ok;

   always_comb begin
      case (va[VA_W-1 -: 3])
         3'b100:  area = AREA_DIR0;
         3'b101:  area = AREA_DIR1;
         3'b110:  area = AREA_HIGH;
         3'b111:  area = AREA_CTRL;
         default: area = AREA_LOW;
      endcase
      in_sq     = (va[VA_W-1 -: 6] == 6'b111000);
      in_oc     = (va[VA_W-1 -: 8] == 8'hE5);
      user_ok   = (area == AREA_LOW) | (in_sq & ~sq_lock) | (in_oc & ocram_en);
      addr_err  = user & ~user_ok;
      need_xlat = xlat_en & ((area == AREA_LOW) | (area == AREA_HIGH));
   end

   // R3: privileged mode never faults
   always_comb begin
      if (!user) a_r3_priv_no_err : assert (!addr_err);
   end

endmodule

// File: rtl/vat_tlb.sv
module vat_tlb
   import vat_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 29,
   parameter int ASID_W  = 8,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int VPN_W  = VA_W - MIN_OFF,
   localparam int PPN_W  = PA_W - MIN_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_shared,
   input  logic [1:0]        wr_size,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PPN_W-1:0]  wr_ppn,
   input  logic [VA_W-1:0]   lk_va,
   input  logic [ASID_W-1:0] lk_asid,
   output logic              lk_hit,
   output logic              lk_multi,
   output logic [PA_W-1:0]   lk_pa
);

   generate
      if (PA_W <= MIN_OFF + 10 || PA_W > VA_W) begin : g_bad_pa
         $error("vat_tlb: PA_W must exceed the largest page offset and not exceed VA_W");
      end
      if (ENTRIES < 2) begin : g_bad_n
         $error("vat_tlb: ENTRIES must be at least 2");
      end
   endgenerate

   logic              e_vld [ENTRIES];
   logic              e_shr [ENTRIES];
   logic [1:0]        e_sz  [ENTRIES];
   logic [VPN_W-1:0]  e_vpn [ENTRIES];
   logic [ASID_W-1:0] e_asid[ENTRIES];
   logic [PPN_W-1:0]  e_ppn [ENTRIES];
   logic [ENTRIES-1:0] hit_vec;
   logic [PA_W-1:0]    ent_pa [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic [VPN_W-1:0] cmp_mask;
      logic [PA_W-1:0]  off_mask;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_vld[i]  <= 1'b0;
            e_shr[i]  <= 1'b0;
            e_sz[i]   <= 2'b00;
            e_vpn[i]  <= '0;
            e_asid[i] <= '0;
            e_ppn[i]  <= '0;
         end else if (wr_en && wr_idx == IDX_W'(i)) begin
            e_vld[i]  <= wr_valid;
            e_shr[i]  <= wr_shared;
            e_sz[i]   <= wr_size;
            e_vpn[i]  <= wr_vpn;
            e_asid[i] <= wr_asid;
            e_ppn[i]  <= wr_ppn;
         end
      end

      always_comb begin
         cmp_mask   = ~((VPN_W'(1) << page_extra(e_sz[i])) - VPN_W'(1));
         off_mask   = (PA_W'(1) << (MIN_OFF + page_extra(e_sz[i]))) - PA_W'(1);
         hit_vec[i] = e_vld[i]
                    & (e_shr[i] | (e_asid[i] == lk_asid))
                    & (((lk_va[VA_W-1:MIN_OFF] ^ e_vpn[i]) & cmp_mask) == '0);
         ent_pa[i]  = ({e_ppn[i], {MIN_OFF{1'b0}}} & ~off_mask)
                    | (lk_va[PA_W-1:0] & off_mask);
      end
   end

   always_comb begin
      lk_pa = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) lk_pa = lk_pa | ent_pa[i];
      end
      lk_hit   = |hit_vec;
      lk_multi = ($countones(hit_vec) > 1);
   end

endmodule

// File: rtl/vat_xlate.sv
module vat_xlate
   import vat_pkg::*;
#(
   parameter int VA_W    = 32,
   parameter int PA_W    = 29,
   parameter int ASID_W  = 8,
   parameter int ENTRIES = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int VPN_W  = VA_W - MIN_OFF,
   localparam int PPN_W  = PA_W - MIN_OFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_user,
   input  logic [ASID_W-1:0] req_asid,
   input  logic              req_xlat_en,
   input  logic              req_sq_lock,
   input  logic              req_ocram_en,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic              wr_valid,
   input  logic              wr_shared,
   input  logic [1:0]        wr_size,
   input  logic [VPN_W-1:0]  wr_vpn,
   input  logic [ASID_W-1:0] wr_asid,
   input  logic [PPN_W-1:0]  wr_ppn,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_pa,
   output logic              rsp_addr_err,
   output logic              rsp_miss,
   output logic              rsp_multi
);

   area_t           area;
   logic            dec_err, dec_xlat;
   logic            t_hit, t_multi;
   logic [PA_W-1:0] t_pa;
   logic [PA_W-1:0] nx_pa;
   logic            nx_err, nx_miss, nx_multi;

   vat_area #(.VA_W(VA_W)) u_area (
      .va(req_va), .user(req_user), .sq_lock(req_sq_lock),
      .ocram_en(req_ocram_en), .xlat_en(req_xlat_en),
      .area(area), .addr_err(dec_err), .need_xlat(dec_xlat)
   );

   vat_tlb #(.VA_W(VA_W), .PA_W(PA_W), .ASID_W(ASID_W), .ENTRIES(ENTRIES)) u_tlb (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_shared(wr_shared),
      .wr_size(wr_size), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn),
      .lk_va(req_va), .lk_asid(req_asid),
      .lk_hit(t_hit), .lk_multi(t_multi), .lk_pa(t_pa)
   );

   always_comb begin
      nx_err   = 1'b0;
      nx_miss  = 1'b0;
      nx_multi = 1'b0;
      nx_pa    = '0;
      if (dec_err) begin
         nx_err = 1'b1;
      end else if (dec_xlat) begin
         nx_miss  = ~t_hit;
         nx_multi = t_multi;
         if (t_hit && !t_multi) nx_pa = t_pa;
      end else begin
         nx_pa = req_va[PA_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_pa       <= '0;
         rsp_addr_err <= 1'b0;
         rsp_miss     <= 1'b0;
         rsp_multi    <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         if (req_valid) begin
            rsp_pa       <= nx_pa;
            rsp_addr_err <= nx_err;
            rsp_miss     <= nx_miss;
            rsp_multi    <= nx_multi;
         end
      end
   end

   // R2: response strobe follows the request strobe by one cycle
   a_r2_rsp_follows : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r2_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R4: user access to the direct regions faults
   a_r4_user_dir_err : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_user && (req_va[VA_W-1 -: 2] == 2'b10)) |=> rsp_addr_err);
   // R4: error result carries no address and no TLB flag
   a_r4_err_clean : assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_addr_err) |-> (!rsp_miss && !rsp_multi && rsp_pa == '0));
   // R7: with translation off, privileged address passes through
   a_r7_bypass : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_user && !req_xlat_en) |=> (rsp_pa == $past(req_va[PA_W-1:0])));
   // R12: multiple hit is never also a miss
   a_r12_multi_not_miss : assert property (@(posedge clk) disable iff (!rst_n)
      rsp_multi |-> !rsp_miss);

endmodule

// File: tb/tb_vat_xlate.sv
module tb_vat_xlate;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_user, req_xlat_en, req_sq_lock, req_ocram_en;
   logic [31:0] req_va;
   logic [7:0]  req_asid;
   logic        wr_en, wr_valid, wr_shared;
   logic [2:0]  wr_idx;
   logic [1:0]  wr_size;
   logic [21:0] wr_vpn;
   logic [7:0]  wr_asid;
   logic [18:0] wr_ppn;
   logic        rsp_valid, rsp_addr_err, rsp_miss, rsp_multi;
   logic [28:0] rsp_pa;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   vat_xlate dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_va(req_va), .req_user(req_user), .req_asid(req_asid),
      .req_xlat_en(req_xlat_en), .req_sq_lock(req_sq_lock), .req_ocram_en(req_ocram_en),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_shared(wr_shared),
      .wr_size(wr_size), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_ppn(wr_ppn),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_addr_err(rsp_addr_err),
      .rsp_miss(rsp_miss), .rsp_multi(rsp_multi)
   );

   task automatic expect_rsp(input string tag, input logic e_err, input logic e_miss,
                             input logic e_multi, input logic [28:0] e_pa);
      total++;
      if (rsp_valid !== 1'b1 || rsp_addr_err !== e_err || rsp_miss !== e_miss ||
          rsp_multi !== e_multi || rsp_pa !== e_pa) begin
         bad++;
         $display("FAIL %s: got v=%b err=%b miss=%b multi=%b pa=%h, want v=1 err=%b miss=%b multi=%b pa=%h",
                  tag, rsp_valid, rsp_addr_err, rsp_miss, rsp_multi, rsp_pa,
                  e_err, e_miss, e_multi, e_pa);
      end
   endtask

   task automatic set_req(input logic [31:0] va, input logic user, input logic [7:0] asid);
      req_va = va; req_user = user; req_asid = asid; req_valid = 1'b1;
   endtask

   // one request, result checked at the negedge after the capturing edge
   task automatic ask(input string tag, input logic [31:0] va, input logic user,
                      input logic [7:0] asid, input logic e_err, input logic e_miss,
                      input logic e_multi, input logic [28:0] e_pa);
      @(negedge clk);
      set_req(va, user, asid);
      @(negedge clk);
      req_valid = 1'b0;
      expect_rsp(tag, e_err, e_miss, e_multi, e_pa);
   endtask

   task automatic put(input logic [2:0] idx, input logic v, input logic sh, input logic [1:0] sz,
                      input logic [31:0] va, input logic [7:0] asid, input logic [28:0] pa);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = idx; wr_valid = v; wr_shared = sh; wr_size = sz;
      wr_vpn = va[31:10]; wr_asid = asid; wr_ppn = pa[28:10];
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic t_reset;
      total++;
      if (rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R1: rsp_valid=%b want 0 after reset", rsp_valid);
      end
      req_xlat_en = 1'b1;
      ask("R1 empty tlb miss", 32'h0001_2777, 1'b0, 8'h11, 1'b0, 1'b1, 1'b0, 29'h0);
      @(negedge clk);
      total++;
      if (rsp_valid !== 1'b0) begin
         bad++;
         $display("FAIL R2: rsp_valid=%b want 0 with no request", rsp_valid);
      end
   endtask

   task automatic t_translate;
      req_xlat_en = 1'b1;
      put(3'd0, 1'b1, 1'b0, 2'b00, 32'h0001_2400, 8'h11, 29'h048_D000);
      put(3'd1, 1'b1, 1'b1, 2'b01, 32'h0040_0000, 8'h00, 29'h020_0000);
      put(3'd2, 1'b1, 1'b0, 2'b10, 32'hC001_0000, 8'h22, 29'h123_0000);
      put(3'd3, 1'b1, 1'b0, 2'b11, 32'h0070_0000, 8'h33, 29'h0A0_0000);
      ask("R8 R9 1KB hit", 32'h0001_2777, 1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 29'h048_D377);
      ask("R9 1KB outside page", 32'h0001_2800, 1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 29'h0);
      ask("R10 shared 4KB any asid", 32'h0040_0ABC, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 29'h020_0ABC);
      ask("R9 64KB high region", 32'hC001_F123, 1'b0, 8'h22, 1'b0, 1'b0, 1'b0, 29'h123_F123);
      ask("R10 asid mismatch", 32'hC001_F123, 1'b0, 8'h23, 1'b0, 1'b1, 1'b0, 29'h0);
      ask("R9 1MB hit", 32'h007A_BCDE, 1'b0, 8'h33, 1'b0, 1'b0, 1'b0, 29'h0AA_BCDE);
      ask("R11 unmapped", 32'h1234_5678, 1'b1, 8'h33, 1'b0, 1'b1, 1'b0, 29'h0);
   endtask

   task automatic t_multi;
      put(3'd4, 1'b1, 1'b1, 2'b01, 32'h0040_0000, 8'h00, 29'h030_0000);
      ask("R12 double hit", 32'h0040_0ABC, 1'b0, 8'h01, 1'b0, 1'b0, 1'b1, 29'h0);
      put(3'd4, 1'b0, 1'b1, 2'b01, 32'h0040_0000, 8'h00, 29'h030_0000);
      ask("R13 invalidated entry", 32'h0040_0ABC, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 29'h020_0ABC);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 3'd5; wr_valid = 1'b1; wr_shared = 1'b0; wr_size = 2'b00;
      wr_vpn = 22'(32'h0090_0000 >> 10); wr_asid = 8'h44; wr_ppn = 19'(29'h015_0000 >> 10);
      set_req(32'h0090_0123, 1'b0, 8'h44);
      @(negedge clk);
      wr_en = 1'b0;
      set_req(32'h0090_0123, 1'b0, 8'h44);
      expect_rsp("R13 same-cycle write not seen", 1'b0, 1'b1, 1'b0, 29'h0);
      @(negedge clk);
      req_valid = 1'b0;
      expect_rsp("R13 write seen next cycle", 1'b0, 1'b0, 1'b0, 29'h015_0123);
   endtask

   task automatic t_perm;
      req_xlat_en = 1'b1; req_sq_lock = 1'b0; req_ocram_en = 1'b0;
      ask("R4 user dir0", 32'h8000_0000, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 29'h0);
      ask("R4 user dir1", 32'hA000_0000, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 29'h0);
      ask("R4 user high mapped", 32'hC001_F123, 1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 29'h0);
      ask("R5 sq open", 32'hE000_0100, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 29'h000_0100);
      ask("R6 ocram closed", 32'hE500_0010, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 29'h0);
      req_sq_lock = 1'b1; req_ocram_en = 1'b1;
      ask("R5 sq locked", 32'hE3FF_FFFC, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 29'h0);
      ask("R6 ocram open", 32'hE500_0010, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 29'h500_0010);
      req_sq_lock = 1'b0;
      ask("R4 gap between windows", 32'hE400_0000, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 29'h0);
      ask("R3 priv control region", 32'hE400_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 29'h400_0000);
      ask("R3 priv dir1", 32'hBFFF_FFFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 29'h1FFF_FFFF);
   endtask

   task automatic t_bypass;
      req_xlat_en = 1'b1;
      ask("R7 dir0 bypass", 32'h9234_5678, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 29'h1234_5678);
      req_xlat_en = 1'b0;
      ask("R7 xlat off priv", 32'h0001_2777, 1'b0, 8'h11, 1'b0, 1'b0, 1'b0, 29'h001_2777);
      ask("R7 xlat off user", 32'h0040_0ABC, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 29'h040_0ABC);
      ask("R7 xlat off high", 32'hC001_F123, 1'b0, 8'h23, 1'b0, 1'b0, 1'b0, 29'h001_F123);
      req_xlat_en = 1'b1;
   endtask

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_user = 1'b0; req_asid = '0;
      req_xlat_en = 1'b0; req_sq_lock = 1'b0; req_ocram_en = 1'b0;
      wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_shared = 1'b0; wr_size = '0;
      wr_vpn = '0; wr_asid = '0; wr_ppn = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_translate();
      t_multi();
      t_same_cycle();
      t_perm();
      t_bypass();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #400000;
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, got hang want completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule